// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Pulse Count and Wave Output

This block is a down counter with a reload latch. A processor programs it through a small byte-wide register port. The counter is twice the data-bus width, which gives 16 bits by default. The processor first writes the low byte of the reload value, which only updates the latch. It then writes the high byte, which completes the latch, copies the whole latch into the counter, clears any pending interrupt and arms the timer.

There are three modes:
- **One-shot:** the timer counts system clocks and raises the interrupt once.
- **Free-running:** the counter reloads itself from the latch at every time-out. It then acts as a frequency divider with a period of latch + 1 clocks.
- **Pulse-count:** the counter ignores the clock. It steps only on falling edges of an external count pin, which passes through a two-flop synchronizer first. It stops at the first time-out, as in one-shot mode.

A time-out happens when a count step arrives while the counter already holds zero. Each time-out sets the interrupt request. When the wave output is enabled, time-outs also drive a square-wave pin:
- In one-shot and pulse modes the pin goes low at the start and high at the time-out.
- In free-running mode the pin toggles at every time-out.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the counter reads 0 (address 0 and 1) and the control register reads 0 (address 2). The status register (address 3) reads 0x04, meaning the interrupt is clear, the timer is idle and the internal wave level is high. irq is 0 and wave_out is 1.
- R2: A write to address 0 changes only the low byte of the reload latch. The counter value and the interrupt flag stay as they were.
- R3: A write to address 1 stores the high latch byte, loads the counter with {written byte, latch low byte}, clears the interrupt flag and arms the timer. All of this is visible one clock later.
- R4: In one-shot mode (control bits 1:0 = 00) and free-running mode (01), an armed counter decrements once per clock. After a start with value N, the counter reads N−k after k clocks for k ≤ N. The time-out comes on clock N+1.
- R5: In one-shot mode a time-out leaves the counter at 0 and disarms the timer (status bit 1 = 0). No further time-out or interrupt follows until the next write to address 1.
- R6: In free-running mode a time-out reloads the counter from the latch and raises the interrupt. The cycle then repeats every latch+1 clocks.
- R7: In pulse-count mode (control bit 1 = 1) the counter changes only on a falling edge of count_pin, seen through two synchronizer flops. Rising edges and a steady pin have no effect. A falling edge while the counter is 0 is a time-out, and the timer stops as in R5.
- R8: Every time-out sets irq and status bit 0. A register read of address 0 (reg_rd high) clears irq, but a time-out in the same clock wins. A write to address 1 also clears irq.
- R9: With control bit 2 set, wave_out follows the internal wave level. A start drives the level low. A time-out drives it high in one-shot and pulse modes and toggles it in free-running mode. With bit 2 clear, wave_out is 1.
- R10: reg_rdata is combinational from reg_addr: 0 gives the counter low byte, 1 the counter high byte, 2 the control register and 3 the status register (bit0 irq, bit1 armed, bit2 wave level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 0 only) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| count_pin | input | 1 | Asynchronous pulse input for pulse-count mode |
| wave_out | output | 1 | Square-wave output |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong count step shows up at the counter read-back within one clock. An off-by-one in the terminal test moves the interrupt edge by exactly one clock, so the bench samples irq at N and N+1 clocks after the start. A bad reload in free-running mode appears in the first count value after the time-out. A missed or extra edge in the synchronizer changes the pulse-mode count three clocks after the pin falls.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    TM_ONESHOT = 2'b00,
    TM_FREERUN = 2'b01,
    TM_PULSE   = 2'b10,
    TM_PULSE2  = 2'b11
  } tmode_e;

  localparam logic [1:0] ADR_CNT_LO = 2'd0;
  localparam logic [1:0] ADR_CNT_HI = 2'd1;
  localparam logic [1:0] ADR_CTRL   = 2'd2;
  localparam logic [1:0] ADR_STAT   = 2'd3;

  function automatic logic mode_is_pulse(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_free(input logic [1:0] m);
    return m == TM_FREERUN;
  endfunction
endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  // previous synchronized level high, current synchronized level low
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/count_core.sv
module count_core
  import timer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_lo_we,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        mode,
  input  logic              fall,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  lat_q,
  output logic              armed_q,
  output logic              tick,
  output logic              tmo
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                   input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign tick = armed_q && (mode_is_pulse(mode) ? fall : 1'b1);
  assign tmo  = tick && (cnt_q == '0) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lat_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      lat_q[CNT_W-1:DATA_W] <= wdata;
      cnt_q   <= join_bytes(wdata, lat_q[DATA_W-1:0]);
      armed_q <= 1'b1;
    end else begin
      if (lat_lo_we) lat_q[DATA_W-1:0] <= wdata;
      if (tmo) begin
        if (mode_is_free(mode)) cnt_q <= lat_q;
        else                    armed_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= step_down(cnt_q);
      end
    end
  end
endmodule

// File: rtl/wave_gen.sv
module wave_gen
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tmo,
  input  logic [1:0] mode,
  input  logic       wave_en,
  output logic       wave_q,
  output logic       wave_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)     wave_q <= 1'b1;
    else if (start) wave_q <= 1'b0;
    else if (tmo)   wave_q <= mode_is_free(mode) ? ~wave_q : 1'b1;
  end

  assign wave_out = wave_en ? wave_q : 1'b1;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import timer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SYNC_FF = 2,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              count_pin,
  output logic              wave_out,
  output logic              irq
);
  logic [2:0]       ctrl_q;
  logic [1:0]       mode;
  logic             wave_en;
  logic             irq_q;
  logic             start, lat_lo_we, ctrl_we, rd_clr;
  logic             fall, tick, tmo, armed, wave_q;
  logic [CNT_W-1:0] cnt_q, lat_q;

  assign mode      = ctrl_q[1:0];
  assign wave_en   = ctrl_q[2];
  assign lat_lo_we = reg_wr && (reg_addr == ADR_CNT_LO);
  assign start     = reg_wr && (reg_addr == ADR_CNT_HI);
  assign ctrl_we   = reg_wr && (reg_addr == ADR_CTRL);
  assign rd_clr    = reg_rd && (reg_addr == ADR_CNT_LO);

  pulse_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(fall)
  );

  count_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .lat_lo_we(lat_lo_we), .start(start),
    .wdata(reg_wdata), .mode(mode), .fall(fall), .cnt_q(cnt_q),
    .lat_q(lat_q), .armed_q(armed), .tick(tick), .tmo(tmo)
  );

  wave_gen u_wave (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo(tmo), .mode(mode),
    .wave_en(wave_en), .wave_q(wave_q), .wave_out(wave_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= reg_wdata[2:0];
      if (tmo)                  irq_q <= 1'b1;
      else if (start || rd_clr) irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_CNT_LO: reg_rdata = cnt_q[DATA_W-1:0];
      ADR_CNT_HI: reg_rdata = cnt_q[CNT_W-1:DATA_W];
      ADR_CTRL:   reg_rdata[2:0] = ctrl_q;
      ADR_STAT:   reg_rdata[2:0] = {wave_q, armed, irq_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_clr,
  input logic              tick,
  input logic              tmo,
  input logic              fall,
  input logic              armed,
  input logic              irq,
  input logic              wave_q,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  lat_q
);
  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> armed && cnt_q == {$past(wdata), $past(lat_q[DATA_W-1:0])});

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tmo && !start) |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode == 2'b00) |=> !armed && cnt_q == '0);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start) |=> $stable(cnt_q));

  assert_free_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode == 2'b01) |=> cnt_q == $past(lat_q));

  assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !fall && !start) |=> $stable(cnt_q));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((start || rd_clr) && !tmo) |=> !irq);

  assert_wave_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wave_q);

  assert_wave_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode == 2'b01) |=> wave_q != $past(wave_q));
endmodule

bind dual_mode_timer timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_clr(rd_clr), .tick(tick),
  .tmo(tmo), .fall(fall), .armed(armed), .irq(irq_q), .wave_q(wave_q),
  .mode(mode), .wdata(reg_wdata), .cnt_q(cnt_q), .lat_q(lat_q)
);

// File: tb/sim_dual_mode_timer.sv
module sim_dual_mode_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       count_pin = 1'b1;
  logic       wave_out, irq;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dual_mode_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count_pin(count_pin), .wave_out(wave_out), .irq(irq)
  );

  // vector: mode, start value, clocks to wait, expected count, expected irq
  typedef struct packed {
    logic [7:0]  mode;
    logic [15:0] n;
    logic [15:0] k;
    logic [15:0] cnt;
    logic        irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd10,     16'd3,    16'd7,      1'b0},
    '{8'h00, 16'd10,     16'd10,   16'd0,      1'b0},
    '{8'h00, 16'd10,     16'd11,   16'd0,      1'b1},
    '{8'h00, 16'd10,     16'd20,   16'd0,      1'b1},
    '{8'h01, 16'd5,      16'd6,    16'd5,      1'b1},
    '{8'h01, 16'd5,      16'd8,    16'd3,      1'b1},
    '{8'h01, 16'h0100,   16'd4,    16'h00FC,   1'b0},
    '{8'h01, 16'd0,      16'd1,    16'd0,      1'b1},
    '{8'h00, 16'd0,      16'd1,    16'd0,      1'b1},
    '{8'h00, 16'h1234,   16'h0034, 16'h1200,   1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic peek_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    peek(2'd0, lo);
    peek(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic start_timer(input logic [7:0] ctrl, input logic [15:0] n);
    bus_wr(2'd2, ctrl);
    bus_wr(2'd0, n[7:0]);
    bus_wr(2'd1, n[15:8]);
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_pin;
    count_pin = 1'b0; wait_clk(4);
    count_pin = 1'b1; wait_clk(4);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] c;
    logic [7:0]  d;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);

    // R1 reset state, R10 map
    peek_cnt(c);   check("R1 count", c, 0);
    peek(2'd2, d); check("R1 ctrl R10", d, 0);
    peek(2'd3, d); check("R1 status R10", d, 8'h04);
    check("R1 irq", irq, 0);
    check("R1 wave", wave_out, 1);

    // R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      start_timer(VECS[i].mode, VECS[i].n);
      wait_clk(int'(VECS[i].k));
      check($sformatf("R4/R6 vec%0d irq", i), irq, VECS[i].irq);
      peek_cnt(c);
      check($sformatf("R4/R6 vec%0d count", i), c, VECS[i].cnt);
    end

    // R2 low write touches only the latch
    start_timer(8'h00, 16'd4);
    wait_clk(10);
    check("R5 irq after one-shot", irq, 1);
    bus_wr(2'd0, 8'h55);
    peek_cnt(c); check("R2 count unchanged", c, 0);
    check("R2 irq unchanged", irq, 1);

    // R8 read clear
    @(negedge clk); reg_addr = 2'd0; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R8 read clears irq", irq, 0);

    // R5 stays idle
    wait_clk(50);
    check("R5 no second irq", irq, 0);
    peek(2'd3, d); check("R5 disarmed", d[1], 0);

    // R3 high write uses latched low byte
    bus_wr(2'd1, 8'h00);
    peek_cnt(c); check("R3 count from latch", c, 16'h0055);
    peek(2'd3, d); check("R3 armed", d[1], 1);

    // R8 time-out wins over read clear
    start_timer(8'h00, 16'd2);
    wait_clk(2);
    reg_addr = 2'd0; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R8 set wins", irq, 1);
    bus_wr(2'd1, 8'h00);
    check("R8 high write clears", irq, 0);

    // R7 pulse counting
    start_timer(8'h02, 16'd3);
    wait_clk(20);
    peek_cnt(c); check("R7 no clock counting", c, 3);
    pulse_pin();
    peek_cnt(c); check("R7 one edge", c, 2);
    pulse_pin(); pulse_pin();
    peek_cnt(c); check("R7 three edges", c, 0);
    check("R7 no irq yet", irq, 0);
    pulse_pin();
    check("R7 timeout irq", irq, 1);
    peek(2'd3, d); check("R7 stopped", d[1], 0);

    // R9 wave output, one-shot
    start_timer(8'h04, 16'd5);
    check("R9 one-shot low", wave_out, 0);
    wait_clk(5);
    check("R9 one-shot still low", wave_out, 0);
    wait_clk(1);
    check("R9 one-shot high", wave_out, 1);

    // R9 wave output, free-run period 4
    start_timer(8'h05, 16'd3);
    wait_clk(3);
    check("R9 free low", wave_out, 0);
    wait_clk(1);
    check("R9 free toggle high", wave_out, 1);
    wait_clk(4);
    check("R9 free toggle low", wave_out, 0);
    bus_wr(2'd2, 8'h01);
    check("R9 disabled high", wave_out, 1);

    finish_run();
  end
endmodule